// File: doc/BRIEF.md
# Clause-22 Management Interface Master

This block runs serial management transactions towards Ethernet PHYs over the two-wire clock/data interface defined for clause 22. Software programs a command word (PHY address, register number and a direction bit) and, for writes, a 16-bit value through a small 32-bit register port. It then sets the status bit in the control word. The block shifts out a full 64-bit frame on MDIO while it generates MDC. On reads it releases the data line for the turnaround and the data field, captures the sixteen bits the PHY returns, and clears the status bit once the frame has ended.

MDC is derived from the system clock by an even division factor `CLK_DIV`, and it only toggles while a frame is in flight. MDIO is presented as three separate wires: output value, output enable and input. The pad tristate is built outside the block. The line is assumed to be pulled high, so a read from an address where no PHY answers returns all ones. The enable bit in the control word gates every start request.

Top module: `mdio_master`

## Requirements
- R1: After reset the command, write-data, read-data and control words all read 0, MDC is low and the output enable is low.
- R2: Register layout (byte offsets). The command word is at 0x7E4, with the register number in bits 4:0, the PHY address in bits 9:5 and the direction in bit 10 (1 = read, 0 = write). The write-data word is at 0x7E8, bits 15:0. The read-data word is at 0x7EC, bits 15:0, and is read-only. The control word is at 0x7F0, with the status/start bit in bit 0 and the enable in bit 3. Unused bits read 0, and the command, write-data and enable fields read back as written.
- R3: A write to the control word that has both bit 0 and bit 3 set, made while idle, starts a frame in the next clock cycle. Bit 0 then reads 1 for the whole frame.
- R4: A control write with bit 0 set and bit 3 clear starts nothing. MDC stays low and bit 0 stays 0.
- R5: During a frame each bit lasts `CLK_DIV` system clocks. MDC is low for the first half of the bit and high for the second half. MDC is low whenever no frame is in flight.
- R6: Frame bits are sent MSB first in this order: 32 ones, start code 0 1, opcode (1 0 for read, 0 1 for write), 5-bit PHY address, 5-bit register number. MDIO changes only at the start of a bit, while MDC is low, and never at an MDC rising edge.
- R7: A write frame drives turnaround bits 1 0 and then the 16 write-data bits, with the output enable high for all 64 bits.
- R8: A read frame drops the output enable at the first turnaround bit (bit 46) and keeps it low to the end of the frame. The block samples MDIO at the MDC rising edge of bits 48 to 63, MSB first.
- R9: Completion follows the last MDC high phase. Bit 0 reads 0 from the clock cycle after the 64th bit ends. In that same cycle a read frame's data is in the read-data word, and a write frame leaves the read-data word unchanged.
- R10: A read from an address where nothing drives the line (input held high) returns 0xFFFF.
- R11: The frame content is fixed when the frame starts. Control writes during a frame start nothing new, and writes to the command or write-data words during a frame do not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable (1 = drive) |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
The hardest case to reach from the ports is a register write that arrives in the middle of a frame. It must change neither the bits already committed to the line nor start a second frame. The stimulus handles this by issuing, while MDC is running, writes of the write-data word, a fresh start command and a new command word on consecutive clocks. The cycle-accurate model then confirms that every later MDC phase and MDIO bit still matches the frame that was originally launched. Read frames are answered by a PHY model that changes the line only at bit boundaries, which exercises sampling at the MDC rising edge. A line left high covers the absent-PHY result.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int unsigned FRAME_BITS = 64;
   localparam int unsigned TA_FIRST   = 46;
   localparam int unsigned DATA_FIRST = 48;
   localparam int unsigned DATA_W     = 16;

   typedef struct packed {
      logic       rd;
      logic [4:0] phy;
      logic [4:0] regn;
   } mdio_cmd_t;

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned OFS_CMD  = 'h7E4,
   parameter int unsigned OFS_WDAT = 'h7E8,
   parameter int unsigned OFS_RDAT = 'h7EC,
   parameter int unsigned OFS_CTRL = 'h7F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              busy,
   input  logic [DATA_W-1:0] rd_word,
   output mdio_cmd_t         cmd,
   output logic [DATA_W-1:0] wr_word,
   output logic              start
);

   localparam logic [ADDR_W-1:0] A_CMD  = OFS_CMD[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_WDAT = OFS_WDAT[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_RDAT = OFS_RDAT[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_CTRL = OFS_CTRL[ADDR_W-1:0];
   localparam int unsigned       CMD_W  = $bits(mdio_cmd_t);

   logic en_q;
   logic unused_wdata;

   assign unused_wdata = ^bus_wdata[31:DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd     <= '0;
         wr_word <= '0;
         en_q    <= 1'b0;
      end else if (bus_wr) begin
         if (bus_addr == A_CMD)  cmd     <= mdio_cmd_t'(bus_wdata[CMD_W-1:0]);
         if (bus_addr == A_WDAT) wr_word <= bus_wdata[DATA_W-1:0];
         if (bus_addr == A_CTRL) en_q    <= bus_wdata[3];
      end
   end

   assign start = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0]
                  && bus_wdata[3] && !busy;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CMD)  bus_rdata[CMD_W-1:0]  = cmd;
      if (bus_addr == A_WDAT) bus_rdata[DATA_W-1:0] = wr_word;
      if (bus_addr == A_RDAT) bus_rdata[DATA_W-1:0] = rd_word;
      if (bus_addr == A_CTRL) bus_rdata[3:0]        = {en_q, 2'b00, busy};
   end

   AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CTRL && bus_wdata[0] && !bus_wdata[3] && !busy) |=> !busy); // R4

endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int unsigned CLK_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_stb,
   output logic bit_end
);

   localparam int unsigned HALF  = CLK_DIV / 2;
   localparam int unsigned CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("mdio_clkgen: CLK_DIV must be even and at least 2");
      end

      if (CLK_DIV == 2) begin : g_toggle
         logic ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ph_q <= 1'b0;
            else if (run) ph_q <= !ph_q;
            else          ph_q <= 1'b0;
         end
         assign mdc      = run && ph_q;
         assign rise_stb = run && !ph_q;
         assign bit_end  = run && ph_q;
      end else begin : g_count
         localparam logic [CNT_W-1:0] C_LAST = CNT_W'(CLK_DIV - 1);
         localparam logic [CNT_W-1:0] C_HALF = CNT_W'(HALF);
         localparam logic [CNT_W-1:0] C_PRE  = CNT_W'(HALF - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt_q <= '0;
            else if (!run)              cnt_q <= '0;
            else if (cnt_q == C_LAST)   cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
         end
         assign mdc      = run && (cnt_q >= C_HALF);
         assign rise_stb = run && (cnt_q == C_PRE);
         assign bit_end  = run && (cnt_q == C_LAST);
      end
   endgenerate

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
   import mdio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mdio_cmd_t         cmd,
   input  logic [DATA_W-1:0] wr_word,
   input  logic              rise_stb,
   input  logic              bit_end,
   input  logic              mdio_i,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rd_word
);

   localparam int unsigned BIT_W = $clog2(FRAME_BITS);
   localparam logic [BIT_W-1:0] B_LAST = BIT_W'(FRAME_BITS - 1);
   localparam logic [BIT_W-1:0] B_TA   = BIT_W'(TA_FIRST);
   localparam logic [BIT_W-1:0] B_DATA = BIT_W'(DATA_FIRST);

   logic                  busy_q;
   logic                  rd_op_q;
   logic [BIT_W-1:0]      bit_q;
   logic [FRAME_BITS-1:0] frame_q;
   logic [DATA_W-1:0]     shift_q;
   logic [DATA_W-1:0]     rd_q;
   logic [FRAME_BITS-1:0] frame_new;

   always_comb begin
      frame_new = {32'hFFFF_FFFF, 2'b01,
                   cmd.rd ? 2'b10 : 2'b01,
                   cmd.phy, cmd.regn,
                   cmd.rd ? 2'b11 : 2'b10,
                   cmd.rd ? {DATA_W{1'b1}} : wr_word};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         rd_op_q <= 1'b0;
         bit_q   <= '0;
         frame_q <= '0;
         shift_q <= '0;
         rd_q    <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q  <= 1'b1;
            rd_op_q <= cmd.rd;
            bit_q   <= '0;
            frame_q <= frame_new;
         end
      end else begin
         if (rise_stb && rd_op_q && bit_q >= B_DATA)
            shift_q <= {shift_q[DATA_W-2:0], mdio_i};
         if (bit_end) begin
            frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
            if (bit_q == B_LAST) begin
               busy_q <= 1'b0;
               if (rd_op_q) rd_q <= shift_q;
            end else begin
               bit_q <= bit_q + 1'b1;
            end
         end
      end
   end

   assign busy    = busy_q;
   assign mdio_o  = frame_q[FRAME_BITS-1];
   assign mdio_oe = busy_q && !(rd_op_q && bit_q >= B_TA);
   assign rd_word = rd_q;

   AST_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(rise_stb)) |-> $stable(mdio_o)); // R6

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int unsigned CLK_DIV  = 8,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned OFS_CMD  = 'h7E4,
   parameter int unsigned OFS_WDAT = 'h7E8,
   parameter int unsigned OFS_RDAT = 'h7EC,
   parameter int unsigned OFS_CTRL = 'h7F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   generate
      if (OFS_CTRL >= (1 << ADDR_W) || OFS_RDAT >= (1 << ADDR_W)
          || OFS_WDAT >= (1 << ADDR_W) || OFS_CMD >= (1 << ADDR_W)) begin : g_bad_ofs
         $error("mdio_master: register offset does not fit ADDR_W");
      end
   endgenerate

   mdio_cmd_t         cmd;
   logic [DATA_W-1:0] wr_word;
   logic [DATA_W-1:0] rd_word;
   logic              start;
   logic              eng_busy;
   logic              rise_stb;
   logic              bit_end;

   mdio_regs #(
      .ADDR_W(ADDR_W), .OFS_CMD(OFS_CMD), .OFS_WDAT(OFS_WDAT),
      .OFS_RDAT(OFS_RDAT), .OFS_CTRL(OFS_CTRL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(eng_busy),
      .rd_word(rd_word), .cmd(cmd), .wr_word(wr_word), .start(start)
   );

   mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(eng_busy), .mdc(mdc),
      .rise_stb(rise_stb), .bit_end(bit_end)
   );

   mdio_engine u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .wr_word(wr_word),
      .rise_stb(rise_stb), .bit_end(bit_end), .mdio_i(mdio_i),
      .busy(eng_busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_word(rd_word)
   );

   AST_DONE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eng_busy) |-> $past(mdc)); // R9

   AST_RELEASE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdio_oe) |-> !mdc); // R8

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

   localparam int DIV  = 8;
   localparam int HALF = DIV / 2;
   localparam logic [11:0] A_CMD  = 12'h7E4;
   localparam logic [11:0] A_WDAT = 12'h7E8;
   localparam logic [11:0] A_RDAT = 12'h7EC;
   localparam logic [11:0] A_CTRL = 12'h7F0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [15:0] last_rd = '0;

   always #5 clk = !clk;

   mdio_master #(.CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus_write(logic [11:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   // expected line value for frame bit b
   function automatic bit exp_bit(int b, bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd);
      if (b < 32)  return 1'b1;
      if (b == 32) return 1'b0;
      if (b == 33) return 1'b1;
      if (b == 34) return rd;
      if (b == 35) return !rd;
      if (b < 41)  return phy[40 - b];
      if (b < 46)  return rg[45 - b];
      if (b == 46) return 1'b1;
      if (b == 47) return 1'b0;
      return wd[63 - b];
   endfunction

   task automatic run_frame(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                            logic [15:0] resp, bit absent, bit disturb);
      bus_write(A_CMD, {21'd0, rd, phy, rg});
      bus_write(A_WDAT, {16'd0, wd});
      bus_write(A_CTRL, 32'h9);           // R3 start with enable
      bus_addr = A_CTRL;
      for (int t = 0; t < 64 * DIV; t++) begin
         int b;
         bit eoe;
         b = t / DIV;
         eoe = !rd || b < 46;
         if (t % DIV == 0) begin
            if (absent || !rd || b < 47) mdio_i = 1'b1;
            else if (b == 47)            mdio_i = 1'b0;
            else                         mdio_i = resp[63 - b];
         end
         if (disturb && t == 10) begin bus_wr = 1'b1; bus_addr = A_WDAT; bus_wdata = 32'h0; end
         if (disturb && t == 11) begin bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h9; end
         if (disturb && t == 12) begin bus_wr = 1'b1; bus_addr = A_CMD;  bus_wdata = 32'h0; end
         if (disturb && t == 13) begin bus_wr = 1'b0; bus_addr = A_CTRL; end
         #1;
         chk("R5 mdc phase", {31'd0, mdc}, {31'd0, (t % DIV) >= HALF});
         chk(rd ? "R8 oe" : "R7 oe", {31'd0, mdio_oe}, {31'd0, eoe});
         if (eoe)
            chk(disturb ? "R11 frame bit" : (b < 46 ? "R6 frame bit" : "R7 data bit"),
                {31'd0, mdio_o}, {31'd0, exp_bit(b, rd, phy, rg, wd)});
         if (bus_addr == A_CTRL && !bus_wr)
            chk("R3 status busy", bus_rdata & 32'h1, 32'h1);
         @(negedge clk);
      end
      mdio_i = 1'b1;
      rd_chk("R9 status clear", A_CTRL, 32'h8);
      chk("R9 mdc idle", {31'd0, mdc}, 32'd0);
      if (rd) last_rd = absent ? 16'hFFFF : resp;
      rd_chk(absent ? "R10 absent read" : "R9 read data", A_RDAT, {16'd0, last_rd});
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      rd_chk("R1 cmd", A_CMD, 0);
      rd_chk("R1 wdat", A_WDAT, 0);
      rd_chk("R1 rdat", A_RDAT, 0);
      rd_chk("R1 ctrl", A_CTRL, 0);
      chk("R1 mdc", {31'd0, mdc}, 0);
      chk("R1 oe", {31'd0, mdio_oe}, 0);
      // R2 layout and masking
      bus_write(A_CMD, 32'hFFFF_FFFF);
      rd_chk("R2 cmd mask", A_CMD, 32'h7FF);
      bus_write(A_WDAT, 32'h1234_ABCD);
      rd_chk("R2 wdat mask", A_WDAT, 32'hABCD);
      bus_write(A_RDAT, 32'h5555);
      rd_chk("R2 rdat read-only", A_RDAT, 0);
      bus_write(A_CTRL, 32'h8);
      rd_chk("R2 enable readback", A_CTRL, 32'h8);
      // R4 start with enable clear
      bus_write(A_CTRL, 32'h1);
      for (int i = 0; i < 3 * DIV; i++) begin
         #1;
         chk("R4 no mdc", {31'd0, mdc}, 0);
         chk("R4 status", bus_rdata, 0);
         @(negedge clk);
      end
      // frames
      run_frame(1'b0, 5'h15, 5'h0A, 16'hA5C3, 16'h0, 1'b0, 1'b0);
      run_frame(1'b1, 5'h01, 5'h1F, 16'h0,   16'h3C5A, 1'b0, 1'b0);
      run_frame(1'b1, 5'h1E, 5'h01, 16'h0,   16'h0000, 1'b1, 1'b0);
      run_frame(1'b0, 5'h0A, 5'h11, 16'h8001, 16'h0, 1'b0, 1'b1);
      rd_chk("R11 cmd after disturb", A_CMD, 0);
      run_frame(1'b1, 5'h00, 5'h00, 16'h0,   16'h8001, 1'b0, 1'b0);
      run_frame(1'b1, 5'h1F, 5'h10, 16'h0,   16'h7FFE, 1'b0, 1'b1);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule